// File: doc/BRIEF.md
# Data-processing ALU with condition flags

A purely combinational integer unit for the execute stage of a small load/store core. Each evaluation takes an operation code, two operands, the four current condition flags (negative, zero, carry, overflow) and a flag-update request. It returns the result, a write-enable for the destination register and the next values of the four flags. The second operand comes in already shifted; shifting, multiplication, condition evaluation and the register file sit elsewhere.

Thirteen operations exist: five logical (AND, OR, bit-clear, move, move-inverted), six additive (add, add with carry, subtract, reverse subtract and the two carry-consuming subtract forms) and two flag-only operations (test and compare). For subtraction the carry output is the inverse of a borrow, and the carry-consuming subtract forms take away the complement of the incoming carry. This lets multi-word subtraction chain through the carry flag in the same way that multi-word addition does.

Top module: `dp_alu`

## Requirements
- R1: Logical results, with op codes AND=0, BIC=1, ORR=2, MOV=3, MVN=4: AND gives a&b, BIC gives a AND NOT b (each set bit of b clears that bit of a), ORR gives a|b, MOV gives b, MVN gives ~b (b=4 gives -5, b=0 gives all ones).
- R2: ADD (code 5) gives a+b and ADC (code 6) gives a+b+c_i. Modulo 2^W, the carry flag takes the carry out of bit W-1.
- R3: SUB (code 7) and CMP (code 12) compute a-b, and RSB (code 9) computes b-a. The carry flag is 1 when no borrow occurs and 0 when one does.
- R4: SBC (code 8) gives a-b-(1-c_i) and RSC (code 10) gives b-a-(1-c_i), with carry following the same no-borrow rule as in R3.
- R5: For codes 5 to 10 and 12, the overflow flag is set exactly when the true signed result falls outside the W-bit two's-complement range.
- R6: Whenever flags update, n_o equals result bit W-1 and z_o is 1 exactly when the W-bit result is zero.
- R7: For codes 0 to 4 and TST (code 11), an updating evaluation passes c_i and v_i through unchanged to c_o and v_o.
- R8: For codes 0 to 10 with set_flags_i=0, all four flag outputs equal the flag inputs.
- R9: TST gives a&b and CMP gives a-b. Both hold res_we_o at 0 and update the flags whatever the value of set_flags_i.
- R10: Codes 0 to 10 drive res_we_o to 1.
- R11: Codes 13 to 15 drive res_we_o to 0 and res_o to 0, and pass all flags through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand, already shifted |
| n_i | input | 1 | Current negative flag |
| z_i | input | 1 | Current zero flag |
| c_i | input | 1 | Current carry flag |
| v_i | input | 1 | Current overflow flag |
| set_flags_i | input | 1 | Request flag update |
| res_o | output | DATA_W | Result |
| res_we_o | output | 1 | Result write-enable |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |

## Verification
Two decisions are made in the same evaluation: whether the destination is written and whether the flags change. The compare and test codes split them, because they update flags and write nothing even when set_flags_i is low. A 4-bit copy of the unit is swept over every code, every operand pair and both values of the incoming carry and the update request. Each output is judged against an arithmetic model that uses wide signed and unsigned integers. Directed 32-bit cases cover the full-width carry, overflow and zero boundaries.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_BIC = 4'd1,
    OP_ORR = 4'd2,
    OP_MOV = 4'd3,
    OP_MVN = 4'd4,
    OP_ADD = 4'd5,
    OP_ADC = 4'd6,
    OP_SUB = 4'd7,
    OP_SBC = 4'd8,
    OP_RSB = 4'd9,
    OP_RSC = 4'd10,
    OP_TST = 4'd11,
    OP_CMP = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic valid;
    logic arith;
    logic flag_only;
  } alu_dec_t;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = opa_i & opb_i;
      OP_BIC:         res_o = opa_i & ~opb_i;
      OP_ORR:         res_o = opa_i | opb_i;
      OP_MOV:         res_o = opb_i;
      OP_MVN:         res_o = ~opb_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int MSB = DATA_W - 1;

  logic              swap, invert, cin;
  logic [DATA_W-1:0] x, y;
  logic [DATA_W:0]   sum;

  always_comb begin
    swap   = 1'b0;
    invert = 1'b0;
    cin    = 1'b0;
    unique case (op_i)
      OP_ADD:         ;
      OP_ADC:         cin = c_i;
      OP_SUB, OP_CMP: begin invert = 1'b1; cin = 1'b1; end
      OP_SBC:         begin invert = 1'b1; cin = c_i;  end
      OP_RSB:         begin swap = 1'b1; invert = 1'b1; cin = 1'b1; end
      OP_RSC:         begin swap = 1'b1; invert = 1'b1; cin = c_i;  end
      default:        ;
    endcase
  end

  // subtraction as x + ~y + cin: carry out is the inverted borrow
  assign x   = swap ? opb_i : opa_i;
  assign y   = invert ? ~(swap ? opa_i : opb_i) : (swap ? opa_i : opb_i);
  assign sum = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};

  assign res_o = sum[MSB:0];
  assign c_o   = sum[DATA_W];
  assign v_o   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int DATA_W = 32
) (
  input  logic              upd_i,
  input  logic              arith_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic              ac_i,
  input  logic              av_i,
  input  logic              n_i,
  input  logic              z_i,
  input  logic              c_i,
  input  logic              v_i,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic              v_o
);
  always_comb begin
    n_o = n_i;
    z_o = z_i;
    c_o = c_i;
    v_o = v_i;
    if (upd_i) begin
      n_o = res_i[DATA_W-1];
      z_o = (res_i == '0);
      if (arith_i) begin
        c_o = ac_i;
        v_o = av_i;
      end
    end
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              n_i,
  input  logic              z_i,
  input  logic              c_i,
  input  logic              v_i,
  input  logic              set_flags_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_we_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic              v_o
);
  alu_dec_t          dec;
  logic [DATA_W-1:0] logic_res, arith_res;
  logic              arith_c, arith_v, upd;

  always_comb begin
    dec = '0;
    unique case (op_i)
      OP_AND, OP_BIC, OP_ORR, OP_MOV, OP_MVN:
        dec.valid = 1'b1;
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC:
        dec = '{valid: 1'b1, arith: 1'b1, flag_only: 1'b0};
      OP_TST:
        dec = '{valid: 1'b1, arith: 1'b0, flag_only: 1'b1};
      OP_CMP:
        dec = '{valid: 1'b1, arith: 1'b1, flag_only: 1'b1};
      default: dec = '0;
    endcase
  end

  alu_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op_i),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .res_o (logic_res)
  );

  alu_arith_unit #(.DATA_W(DATA_W)) u_arith (
    .op_i  (op_i),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .c_i   (c_i),
    .res_o (arith_res),
    .c_o   (arith_c),
    .v_o   (arith_v)
  );

  assign res_o    = dec.arith ? arith_res : logic_res;
  assign res_we_o = dec.valid & ~dec.flag_only;
  assign upd      = dec.flag_only | (dec.valid & set_flags_i);

  alu_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .upd_i   (upd),
    .arith_i (dec.arith),
    .res_i   (res_o),
    .ac_i    (arith_c),
    .av_i    (arith_v),
    .n_i     (n_i),
    .z_i     (z_i),
    .c_i     (c_i),
    .v_i     (v_i),
    .n_o     (n_o),
    .z_o     (z_o),
    .c_o     (c_o),
    .v_o     (v_o)
  );
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              n_i,
  input logic              z_i,
  input logic              c_i,
  input logic              v_i,
  input logic              set_flags_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_we_o,
  input logic              n_o,
  input logic              z_o,
  input logic              c_o,
  input logic              v_o
);
  logic is_flag_only, is_logic, is_unused, is_used;

  assign is_flag_only = (op_i == OP_TST) || (op_i == OP_CMP);
  assign is_logic     = (op_i <= OP_MVN) || (op_i == OP_TST);
  assign is_unused    = (op_i > OP_CMP);
  assign is_used      = !is_unused && !is_flag_only;

  always_comb begin
    AST_FLAG_ONLY_NO_WRITE: assert (!is_flag_only || !res_we_o); // R9
    AST_USED_WRITES: assert (!is_used || res_we_o); // R10
    AST_HOLD_FLAGS: assert (!(is_used && !set_flags_i) ||
                            ({n_o, z_o, c_o, v_o} == {n_i, z_i, c_i, v_i})); // R8
    AST_LOGIC_KEEPS_CV: assert (!(is_logic && (set_flags_i || is_flag_only)) ||
                                ({c_o, v_o} == {c_i, v_i})); // R7
    AST_ZERO_FLAG: assert (!(is_flag_only || (is_used && set_flags_i)) ||
                           (z_o == (res_o == '0))); // R6
    AST_NEG_FLAG: assert (!(is_flag_only || (is_used && set_flags_i)) ||
                          (n_o == res_o[DATA_W-1])); // R6
    AST_UNUSED_QUIET: assert (!is_unused ||
                              (!res_we_o && res_o == '0 &&
                               {n_o, z_o, c_o, v_o} == {n_i, z_i, c_i, v_i})); // R11
  end
endmodule

bind dp_alu dp_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i        (op_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .n_i         (n_i),
  .z_i         (z_i),
  .c_i         (c_i),
  .v_i         (v_i),
  .set_flags_i (set_flags_i),
  .res_o       (res_o),
  .res_we_o    (res_we_o),
  .n_o         (n_o),
  .z_o         (z_o),
  .c_o         (c_o),
  .v_o         (v_o)
);

// File: tb/tb_dp_alu.sv
`timescale 1ns/1ps
module tb_dp_alu;
  localparam int W  = 32;
  localparam int WS = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]    op;
  logic [W-1:0]  a, b, res;
  logic          n, z, c, v, sf, we, no, zo, co, vo;

  logic [3:0]    op_s;
  logic [WS-1:0] a_s, b_s, res_s;
  logic          n_s, z_s, c_s, v_s, sf_s, we_s, no_s, zo_s, co_s, vo_s;

  dp_alu #(.DATA_W(W)) dut (
    .op_i(op), .opa_i(a), .opb_i(b), .n_i(n), .z_i(z), .c_i(c), .v_i(v),
    .set_flags_i(sf), .res_o(res), .res_we_o(we),
    .n_o(no), .z_o(zo), .c_o(co), .v_o(vo)
  );

  dp_alu #(.DATA_W(WS)) dut_s (
    .op_i(op_s), .opa_i(a_s), .opb_i(b_s), .n_i(n_s), .z_i(z_s), .c_i(c_s), .v_i(v_s),
    .set_flags_i(sf_s), .res_o(res_s), .res_we_o(we_s),
    .n_o(no_s), .z_o(zo_s), .c_o(co_s), .v_o(vo_s)
  );

  task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s op=%0d got res=%h we=%b nzcv=%b exp res=%h we=%b nzcv=%b",
               req, op, got[36:5], got[4], got[3:0], exp[36:5], exp[4], exp[3:0]);
    end
  endtask

  // full-width directed case; expected value is {res, we, n, z, c, v}
  task automatic run32(input string req, input logic [3:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, input logic [3:0] fl, input logic s,
                       input logic [W-1:0] er, input logic ew, input logic [3:0] ef);
    op = o; a = x; b = y; {n, z, c, v} = fl; sf = s;
    #2;
    check(req, {res, we, no, zo, co, vo}, {er, ew, ef});
  endtask

  function automatic longint sx(input longint x, input int w);
    return x[w-1] ? x - (longint'(1) << w) : x;
  endfunction

  task automatic model(input int w, input int o, input longint x, input longint y,
                       input bit fn, input bit fz, input bit fc, input bit fv, input bit s,
                       output longint r, output bit ew,
                       output bit en, output bit ez, output bit ec, output bit ev);
    longint mask = (longint'(1) << w) - 1;
    longint smax = (longint'(1) << (w - 1)) - 1;
    longint smin = -(longint'(1) << (w - 1));
    longint m, t, sr, br;
    bit ar = 1'b0, upd, cc = 1'b0, vv = 1'b0;
    r = 0;
    case (o)
      0, 11: r = x & y;
      1:  r = x & ~y & mask;
      2:  r = x | y;
      3:  r = y;
      4:  r = ~y & mask;
      5, 6: begin
        ar = 1'b1;
        br = (o == 6) ? longint'(fc) : 0;
        t  = x + y + br;
        cc = t > mask;
        sr = sx(x, w) + sx(y, w) + br;
        vv = (sr > smax) || (sr < smin);
        r  = t & mask;
      end
      7, 8, 9, 10, 12: begin
        ar = 1'b1;
        br = (o == 8 || o == 10) ? longint'(!fc) : 0;
        m  = (o == 9 || o == 10) ? y : x;
        t  = (o == 9 || o == 10) ? x : y;
        cc = m >= t + br;
        sr = sx(m, w) - sx(t, w) - br;
        vv = (sr > smax) || (sr < smin);
        r  = (m - t - br) & mask;
      end
      default: r = 0;
    endcase
    ew  = (o <= 10);
    upd = (o == 11) || (o == 12) || (o <= 10 && s);
    en = fn; ez = fz; ec = fc; ev = fv;
    if (upd) begin
      en = r[w-1];
      ez = (r == 0);
      if (ar) begin ec = cc; ev = vv; end
    end
  endtask

  function automatic string req_of(input int o);
    case (o)
      0, 1, 2, 3, 4: return "R1/R7/R8";
      5, 6:          return "R2/R5/R6";
      7, 9:          return "R3/R5/R6";
      8, 10:         return "R4/R5";
      11, 12:        return "R9";
      default:       return "R11";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 4'd0; a = '0; b = '0; {n, z, c, v} = 4'b0; sf = 1'b0;
    op_s = 4'd0; a_s = '0; b_s = '0; {n_s, z_s, c_s, v_s} = 4'b0; sf_s = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // idle after reset: AND of zeros, no update
    run32("R10 idle", 4'd0, 32'h0, 32'h0, 4'b0000, 1'b0, 32'h0, 1'b1, 4'b0000);
    run32("R1 MVN 4", 4'd4, 32'h0, 32'd4, 4'b0000, 1'b0, 32'hFFFF_FFFB, 1'b1, 4'b0000);
    run32("R1 MVN 0", 4'd4, 32'h0, 32'd0, 4'b0000, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'b1000);
    run32("R1 BIC", 4'd1, 32'hFF, 32'hB, 4'b0011, 1'b1, 32'hF4, 1'b1, 4'b0011);
    run32("R7 ORR keeps CV", 4'd2, 32'h0, 32'h0, 4'b1011, 1'b1, 32'h0, 1'b1, 4'b0111);
    run32("R3 SUB no borrow", 4'd7, 32'd5, 32'd3, 4'b0000, 1'b1, 32'd2, 1'b1, 4'b0010);
    run32("R3 SUB borrow", 4'd7, 32'd3, 32'd5, 4'b0010, 1'b1, 32'hFFFF_FFFE, 1'b1, 4'b1000);
    run32("R3 RSB", 4'd9, 32'd1, 32'd256, 4'b0000, 1'b1, 32'd255, 1'b1, 4'b0010);
    run32("R4 SBC c=0", 4'd8, 32'd10, 32'd3, 4'b0000, 1'b1, 32'd6, 1'b1, 4'b0010);
    run32("R4 RSC c=1", 4'd10, 32'd3, 32'd10, 4'b0010, 1'b1, 32'd7, 1'b1, 4'b0010);
    run32("R4 SBC 0-0 borrow", 4'd8, 32'd0, 32'd0, 4'b0000, 1'b1, 32'hFFFF_FFFF, 1'b1, 4'b1000);
    run32("R5 ADD overflow", 4'd5, 32'h7FFF_FFFF, 32'd1, 4'b0000, 1'b1, 32'h8000_0000, 1'b1, 4'b1001);
    run32("R5 SUB overflow", 4'd7, 32'h8000_0000, 32'd1, 4'b0000, 1'b1, 32'h7FFF_FFFF, 1'b1, 4'b0011);
    run32("R2 ADC wrap", 4'd6, 32'hFFFF_FFFF, 32'd0, 4'b0010, 1'b1, 32'h0, 1'b1, 4'b0110);
    run32("R8 ADD no update", 4'd5, 32'hFFFF_FFFF, 32'd1, 4'b1001, 1'b0, 32'h0, 1'b1, 4'b1001);
    run32("R9 CMP equal", 4'd12, 32'd42, 32'd42, 4'b1001, 1'b0, 32'h0, 1'b0, 4'b0110);
    run32("R9 TST miss", 4'd11, 32'd1, 32'd2, 4'b0011, 1'b0, 32'h0, 1'b0, 4'b0111);
    run32("R11 unused code", 4'd14, 32'd7, 32'd9, 4'b1010, 1'b1, 32'h0, 1'b0, 4'b1010);

    // exhaustive sweep of the narrow instance
    for (int o = 0; o < 16; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int k = 0; k < 4; k++) begin
            longint r;
            bit ew, en, ez, ec, ev;
            op_s = 4'(o); a_s = 4'(x); b_s = 4'(y);
            c_s = k[0]; sf_s = k[1];
            n_s = x[0] ^ y[1]; z_s = y[0]; v_s = x[3];
            model(WS, o, longint'(x), longint'(y), n_s, z_s, c_s, v_s, sf_s,
                  r, ew, en, ez, ec, ev);
            #2;
            checks++;
            if ({res_s, we_s, no_s, zo_s, co_s, vo_s} !== {r[3:0], ew, en, ez, ec, ev}) begin
              errors++;
              $display("FAIL %s op=%0d a=%0d b=%0d c=%0d sf=%0d got res=%h we=%b nzcv=%b exp res=%h we=%b nzcv=%b",
                       req_of(o), o, x, y, k[0], k[1], res_s, we_s,
                       {no_s, zo_s, co_s, vo_s}, r[3:0], ew, {en, ez, ec, ev});
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule